// File: doc/BRIEF.md
# DRAM Power-Up and Self-Refresh Strobe Sequencer

This block owns the row and column strobes of an asynchronous DRAM while the memory is being brought up and while it is parked in self-refresh. After reset it holds both strobes high for a long settling pause. It then runs a fixed number of refresh cycles in which the column strobe always falls before the row strobe (CAS-before-RAS order), and raises a ready flag once the last of those cycles has finished its precharge.

Once ready, a single-cycle sleep request puts the memory into self-refresh. The column strobe goes low, the row strobe follows, and the row strobe is then held low for at least the minimum self-refresh time. A single-cycle wake request ends self-refresh. If the wake request comes early, it is remembered and acted on as soon as the minimum time is met. On exit, the column strobe stays low for a hold window after the row strobe rises. Ready returns only when the row strobe has been high for the precharge time of the selected speed grade.

Every duration is a parameter in nanoseconds. At elaboration it is converted to whole clock cycles, rounding up, using a clock-period parameter. The defaults assume an 8 ns clock.

Top module: `dram_sleep_seq`

## Requirements
- R1: While reset is asserted, ras_n_o=1, cas_n_o=1, ready_o=0 and busy_o=1. After reset is released, both strobes stay high for at least PAUSE_NS (12500 cycles at defaults) before any strobe falls.
- R2: After the pause, exactly INIT_CYCLES (8) initialization cycles run. Each cycle is: cas_n_o low with ras_n_o high for 2 cycles, then both low for 10 cycles, then both high for 8 cycles.
- R3: ready_o rises in the cycle right after the last initialization precharge cycle. While ready_o=1, busy_o=0 and both strobes are high.
- R4: A sleep request pulse seen outside self-refresh is held until the sequencer is idle. A request held from before ready gives a ready window of exactly 1 cycle. A request pulsed on the k-th ready cycle gives a ready window of k+1 cycles.
- R5: Self-refresh entry drives cas_n_o low with ras_n_o high for 2 cycles. Both strobes are then low with busy_o=1 for exactly SR_MIN_LOW_NS (12500 cycles).
- R6: A wake request received during self-refresh entry or during the minimum low time is latched. ras_n_o rises in the cycle right after the minimum low time ends.
- R7: When the minimum low time ends with no wake pending, both strobes stay low with busy_o=0 and ready_o=0. A wake pulse on the k-th such cycle gives a window of k+1 cycles.
- R8: On exit, ras_n_o is high and cas_n_o is low for 7 cycles (50 ns). Then both are high until ras_n_o has been high for 17 cycles (130 ns, SLOW_GRADE=0) or 19 cycles (150 ns, SLOW_GRADE=1), and ready_o rises in the next cycle.
- R9: A wake request outside self-refresh has no effect. A sleep request during self-refresh entry, the minimum low time, or the parked window has no effect.
- R10: Every fall of ras_n_o happens with cas_n_o already low in the previous cycle. cas_n_o never rises while ras_n_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_req_i | input | 1 | Single-cycle request to enter self-refresh |
| wake_req_i | input | 1 | Single-cycle request to leave self-refresh |
| ras_n_o | output | 1 | Row strobe to the DRAM, active low, registered |
| cas_n_o | output | 1 | Column strobe to the DRAM, active low, registered |
| ready_o | output | 1 | Initialization complete and the DRAM is free for normal use |
| busy_o | output | 1 | A timed strobe phase is in progress |

## Verification
The bench records every run of constant strobe and flag values and checks the length of each run exactly. A design with an off-by-one timer, a ninth or seventh initialization cycle, or a ready flag raised during the final precharge therefore produces a run that is one cycle or one segment wrong.

It sends a sleep request during the power-up pause, so a design that drops early requests would sit in ready indefinitely. It sends wake requests both before the minimum low time ends and after it, so a design that drops early wakes would park instead of leaving on time. It also sends a wake request while idle and a sleep request during self-refresh; a design that latched either would skip the parked window or re-enter self-refresh without being asked.

A second instance set to the slow grade must keep ready low for two cycles longer after the row strobe rises. A design that ignored the grade parameter would show the same 17-cycle window on both instances.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [3:0] {
    ST_PAUSE    = 4'd0,
    ST_INIT_CAS = 4'd1,
    ST_INIT_RAS = 4'd2,
    ST_INIT_PRE = 4'd3,
    ST_IDLE     = 4'd4,
    ST_SR_CAS   = 4'd5,
    ST_SR_LOW   = 4'd6,
    ST_SR_WAIT  = 4'd7,
    ST_SR_HOLD  = 4'd8,
    ST_SR_TAIL  = 4'd9
  } seq_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic ready;
    logic busy;
  } strobe_t;

  localparam strobe_t STROBE_RST = '{ras_n: 1'b1, cas_n: 1'b1, ready: 1'b0, busy: 1'b1};

  // nanoseconds to whole cycles, rounded up, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic strobe_t strobes_of(input seq_state_e s);
    strobe_t o;
    case (s)
      ST_PAUSE:    o = '{ras_n: 1'b1, cas_n: 1'b1, ready: 1'b0, busy: 1'b1};
      ST_INIT_CAS: o = '{ras_n: 1'b1, cas_n: 1'b0, ready: 1'b0, busy: 1'b1};
      ST_INIT_RAS: o = '{ras_n: 1'b0, cas_n: 1'b0, ready: 1'b0, busy: 1'b1};
      ST_INIT_PRE: o = '{ras_n: 1'b1, cas_n: 1'b1, ready: 1'b0, busy: 1'b1};
      ST_IDLE:     o = '{ras_n: 1'b1, cas_n: 1'b1, ready: 1'b1, busy: 1'b0};
      ST_SR_CAS:   o = '{ras_n: 1'b1, cas_n: 1'b0, ready: 1'b0, busy: 1'b1};
      ST_SR_LOW:   o = '{ras_n: 1'b0, cas_n: 1'b0, ready: 1'b0, busy: 1'b1};
      ST_SR_WAIT:  o = '{ras_n: 1'b0, cas_n: 1'b0, ready: 1'b0, busy: 1'b0};
      ST_SR_HOLD:  o = '{ras_n: 1'b1, cas_n: 1'b0, ready: 1'b0, busy: 1'b1};
      ST_SR_TAIL:  o = '{ras_n: 1'b1, cas_n: 1'b1, ready: 1'b0, busy: 1'b1};
      default:     o = STROBE_RST;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[N-2:0], 1'b1};
  end

  assign srst_no = sync_q[N-1];
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned W       = 14,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i | (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = val_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= W'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  // R1: a running window only ever shortens by one cycle per clock
  assert_timer_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/seq_req_latch.sv
module seq_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic wake_req_i,
  input  logic in_sr_i,
  input  logic take_sleep_i,
  input  logic take_wake_i,
  output logic sleep_pend_o,
  output logic wake_pend_o
);
  logic sleep_q, sleep_d, wake_q, wake_d;
  logic sleep_set, wake_set;

  assign sleep_set = sleep_req_i & ~in_sr_i;
  assign wake_set  = wake_req_i & in_sr_i;

  always_comb begin
    sleep_d = take_sleep_i ? 1'b0 : (sleep_q | sleep_set);
    wake_d  = take_wake_i  ? 1'b0 : (wake_q  | wake_set);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      sleep_q <= sleep_d;
      wake_q  <= wake_d;
    end
  end

  assign sleep_pend_o = sleep_q;
  assign wake_pend_o  = wake_q;

  // R9: a held wake can only stem from a cycle spent in self-refresh
  assert_wake_only_in_sr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_q |-> $past(in_sr_i));

  // R4: a held sleep request survives until the sequencer consumes it
  assert_sleep_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_q && !take_sleep_i) |=> sleep_q);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int unsigned TW      = 14,
  parameter int unsigned INIT_N  = 8,
  parameter int unsigned SETUP_C = 2,
  parameter int unsigned IRAS_C  = 10,
  parameter int unsigned IPRE_C  = 8,
  parameter int unsigned SRMIN_C = 12500,
  parameter int unsigned HOLD_C  = 7,
  parameter int unsigned TAIL_C  = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          sleep_pend_i,
  input  logic          wake_pend_i,
  output logic          load_o,
  output logic [TW-1:0] val_o,
  output logic          take_sleep_o,
  output logic          take_wake_o,
  output logic          in_sr_o,
  output logic          ras_n_o,
  output logic          cas_n_o,
  output logic          ready_o,
  output logic          busy_o
);
  localparam int unsigned BW = $clog2(INIT_N + 1);
  localparam logic [BW-1:0] LAST_BURST = BW'(INIT_N - 1);
  localparam logic [TW-1:0] V_SETUP = TW'(SETUP_C - 1);
  localparam logic [TW-1:0] V_IRAS  = TW'(IRAS_C - 1);
  localparam logic [TW-1:0] V_IPRE  = TW'(IPRE_C - 1);
  localparam logic [TW-1:0] V_SRMIN = TW'(SRMIN_C - 1);
  localparam logic [TW-1:0] V_HOLD  = TW'(HOLD_C - 1);
  localparam logic [TW-1:0] V_TAIL  = TW'(TAIL_C - 1);

  seq_state_e      state_q, state_d;
  logic [BW-1:0]   burst_q, burst_d;
  logic            burst_en;
  strobe_t         strobe_q, strobe_d;

  always_comb begin
    state_d      = state_q;
    load_o       = 1'b0;
    val_o        = '0;
    burst_d      = burst_q;
    burst_en     = 1'b0;
    take_sleep_o = 1'b0;
    take_wake_o  = 1'b0;
    case (state_q)
      ST_PAUSE: if (done_i) begin
        state_d = ST_INIT_CAS; load_o = 1'b1; val_o = V_SETUP;
      end
      ST_INIT_CAS: if (done_i) begin
        state_d = ST_INIT_RAS; load_o = 1'b1; val_o = V_IRAS;
      end
      ST_INIT_RAS: if (done_i) begin
        state_d = ST_INIT_PRE; load_o = 1'b1; val_o = V_IPRE;
      end
      ST_INIT_PRE: if (done_i) begin
        if (burst_q == LAST_BURST) begin
          state_d = ST_IDLE;
        end else begin
          state_d  = ST_INIT_CAS; load_o = 1'b1; val_o = V_SETUP;
          burst_en = 1'b1;        burst_d = burst_q + 1'b1;
        end
      end
      ST_IDLE: if (sleep_pend_i) begin
        state_d = ST_SR_CAS; load_o = 1'b1; val_o = V_SETUP; take_sleep_o = 1'b1;
      end
      ST_SR_CAS: if (done_i) begin
        state_d = ST_SR_LOW; load_o = 1'b1; val_o = V_SRMIN;
      end
      ST_SR_LOW: if (done_i) begin
        if (wake_pend_i) begin
          state_d = ST_SR_HOLD; load_o = 1'b1; val_o = V_HOLD; take_wake_o = 1'b1;
        end else begin
          state_d = ST_SR_WAIT;
        end
      end
      ST_SR_WAIT: if (wake_pend_i) begin
        state_d = ST_SR_HOLD; load_o = 1'b1; val_o = V_HOLD; take_wake_o = 1'b1;
      end
      ST_SR_HOLD: if (done_i) begin
        state_d = ST_SR_TAIL; load_o = 1'b1; val_o = V_TAIL;
      end
      ST_SR_TAIL: if (done_i) begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_PAUSE;
    endcase
  end

  assign strobe_d = strobes_of(state_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_PAUSE;
      strobe_q <= STROBE_RST;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       burst_q <= '0;
    else if (burst_en) burst_q <= burst_d;
  end

  assign in_sr_o = (state_q == ST_SR_CAS) || (state_q == ST_SR_LOW) || (state_q == ST_SR_WAIT);
  assign ras_n_o = strobe_q.ras_n;
  assign cas_n_o = strobe_q.cas_n;
  assign ready_o = strobe_q.ready;
  assign busy_o  = strobe_q.busy;

  // checker counter: cycles of row strobe low, saturating at the minimum
  logic [TW-1:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          low_run_q <= '0;
    else if (strobe_q.ras_n)              low_run_q <= '0;
    else if (low_run_q != TW'(SRMIN_C))   low_run_q <= low_run_q + 1'b1;
  end

  // R10: row strobe falls only after the column strobe is already low
  assert_cbr_order_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_q.ras_n) |-> (!strobe_q.cas_n && !$past(strobe_q.cas_n)));

  // R10: column strobe never rises under a low row strobe
  assert_cas_under_ras_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_q.cas_n) |-> strobe_q.ras_n);

  // R3: ready implies the full burst count was run
  assert_ready_after_burst_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (burst_q == LAST_BURST));

  // R6: leaving self-refresh only after the minimum low time
  assert_sr_min_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(strobe_q.ras_n) && !strobe_q.cas_n) |-> (low_run_q == TW'(SRMIN_C)));
endmodule

// File: rtl/dram_sleep_seq.sv
module dram_sleep_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS  = 8,
  parameter int unsigned PAUSE_NS       = 100000,
  parameter int unsigned INIT_CYCLES    = 8,
  parameter int unsigned CBR_SETUP_NS   = 10,
  parameter int unsigned INIT_RAS_NS    = 80,
  parameter int unsigned INIT_PRE_NS    = 60,
  parameter int unsigned SR_MIN_LOW_NS  = 100000,
  parameter int unsigned SR_PRE_FAST_NS = 130,
  parameter int unsigned SR_PRE_SLOW_NS = 150,
  parameter int unsigned SR_CAS_HOLD_NS = 50,
  parameter bit          SLOW_GRADE     = 1'b0,
  parameter int unsigned RST_STAGES     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic wake_req_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic ready_o,
  output logic busy_o
);
  localparam int unsigned PAUSE_C = ns_to_cyc(PAUSE_NS, CLK_PERIOD_NS);
  localparam int unsigned SETUP_C = ns_to_cyc(CBR_SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned IRAS_C  = ns_to_cyc(INIT_RAS_NS, CLK_PERIOD_NS);
  localparam int unsigned IPRE_C  = ns_to_cyc(INIT_PRE_NS, CLK_PERIOD_NS);
  localparam int unsigned SRMIN_C = ns_to_cyc(SR_MIN_LOW_NS, CLK_PERIOD_NS);
  localparam int unsigned HOLD_C  = ns_to_cyc(SR_CAS_HOLD_NS, CLK_PERIOD_NS);
  localparam int unsigned PRE_C   = SLOW_GRADE ? ns_to_cyc(SR_PRE_SLOW_NS, CLK_PERIOD_NS)
                                               : ns_to_cyc(SR_PRE_FAST_NS, CLK_PERIOD_NS);
  localparam int unsigned TAIL_C  = (PRE_C > HOLD_C) ? (PRE_C - HOLD_C) : 1;
  localparam int unsigned MAX_C   = max_u(max_u(max_u(PAUSE_C, SRMIN_C), max_u(IRAS_C, IPRE_C)),
                                          max_u(max_u(SETUP_C, HOLD_C), TAIL_C));
  localparam int unsigned TW      = $clog2(MAX_C + 1);

  logic          srst_n;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          sleep_pend, wake_pend, take_sleep, take_wake, in_sr;

  seq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (srst_n)
  );

  seq_timer #(.W(TW), .RST_VAL(PAUSE_C - 1)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (srst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  seq_req_latch u_req (
    .clk_i        (clk_i),
    .rst_ni       (srst_n),
    .sleep_req_i  (sleep_req_i),
    .wake_req_i   (wake_req_i),
    .in_sr_i      (in_sr),
    .take_sleep_i (take_sleep),
    .take_wake_i  (take_wake),
    .sleep_pend_o (sleep_pend),
    .wake_pend_o  (wake_pend)
  );

  seq_fsm #(
    .TW(TW), .INIT_N(INIT_CYCLES), .SETUP_C(SETUP_C), .IRAS_C(IRAS_C), .IPRE_C(IPRE_C),
    .SRMIN_C(SRMIN_C), .HOLD_C(HOLD_C), .TAIL_C(TAIL_C)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (srst_n),
    .done_i       (tmr_done),
    .sleep_pend_i (sleep_pend),
    .wake_pend_i  (wake_pend),
    .load_o       (tmr_load),
    .val_o        (tmr_val),
    .take_sleep_o (take_sleep),
    .take_wake_o  (take_wake),
    .in_sr_o      (in_sr),
    .ras_n_o      (ras_n_o),
    .cas_n_o      (cas_n_o),
    .ready_o      (ready_o),
    .busy_o       (busy_o)
  );
endmodule

// File: tb/tb_dram_sleep_seq.sv
`timescale 1ns/1ps
module tb_dram_sleep_seq;
  localparam int unsigned P_CYC  = 12500;
  localparam int unsigned SET_C  = 2;
  localparam int unsigned IRAS   = 10;
  localparam int unsigned IPRE   = 8;
  localparam int unsigned SRMIN  = 12500;
  localparam int unsigned HOLD   = 7;
  localparam int unsigned TAIL_F = 10;

  logic clk, rst_n, sleep_req, wake_req;
  logic ras_n, cas_n, ready, busy;
  logic ras_s, cas_s, ready_s, busy_s;

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          finished = 1'b0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  dram_sleep_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .ready_o(ready), .busy_o(busy)
  );

  dram_sleep_seq #(.SLOW_GRADE(1'b1)) dut_slow (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
    .ras_n_o(ras_s), .cas_n_o(cas_s), .ready_o(ready_s), .busy_o(busy_s)
  );

  typedef struct packed {
    logic [3:0]  key;   // {ras_n, cas_n, ready, busy}
    int unsigned lo;
    int unsigned hi;
    int unsigned req;
  } seg_t;

  seg_t exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int unsigned act, input int unsigned expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [3:0] key, input int unsigned lo, input int unsigned hi,
                      input int unsigned req);
    seg_t s;
    s.key = key; s.lo = lo; s.hi = hi; s.req = req;
    exp_q.push_back(s);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: measures each run of constant outputs and compares it with the queue
  logic [3:0]  mon_prev;
  int unsigned mon_len;
  bit          mon_on = 1'b0;
  always @(negedge clk) begin
    logic [3:0] key;
    seg_t e;
    key = {ras_n, cas_n, ready, busy};
    if (!rst_n) begin
      mon_on = 1'b0;
    end else if (!mon_on) begin
      mon_on = 1'b1; mon_prev = key; mon_len = 1;
    end else if (key == mon_prev) begin
      mon_len++;
    end else begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected segment: actual key %b len %0d expected none", mon_prev, mon_len);
      end else begin
        e = exp_q.pop_front();
        if (e.key != mon_prev || mon_len < e.lo || mon_len > e.hi) begin
          errors++;
          $display("FAIL R%0d segment: actual key %b len %0d expected key %b len %0d..%0d",
                   e.req, mon_prev, mon_len, e.key, e.lo, e.hi);
        end
      end
      mon_prev = key; mon_len = 1;
    end
  end

  // slow-grade instance: exit window length up to ready (R8)
  initial begin
    int unsigned hi_cnt, cas_lo;
    hi_cnt = 0; cas_lo = 0;
    @(posedge rst_n);
    @(negedge clk);
    while (!ready_s) @(negedge clk);
    while (ras_s)    @(negedge clk);
    while (!ras_s)   @(negedge clk);
    while (!ready_s) begin
      hi_cnt++;
      if (!cas_s) cas_lo++;
      @(negedge clk);
    end
    chk(hi_cnt == 19, "R8", "slow grade row-high cycles before ready", hi_cnt, 19);
    chk(cas_lo == HOLD, "R8", "slow grade column hold cycles", cas_lo, HOLD);
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // driver
  initial begin
    rst_n = 1'b0; sleep_req = 1'b0; wake_req = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(ras_n == 1'b1, "R1", "ras_n in reset", ras_n, 1);
    chk(cas_n == 1'b1, "R1", "cas_n in reset", cas_n, 1);
    chk(ready == 1'b0, "R1", "ready in reset", ready, 0);
    chk(busy  == 1'b1, "R1", "busy in reset",  busy, 1);

    // R1 pause, R2 and R10 eight CAS-before-RAS cycles
    push(4'b1101, P_CYC, P_CYC + 3, 1);
    for (int i = 0; i < 8; i++) begin
      push(4'b1001, SET_C, SET_C, 2);
      push(4'b0001, IRAS, IRAS, 2);
      push(4'b1101, IPRE, IPRE, 2);
    end
    push(4'b1110, 1, 1, 4);           // R3/R4: early request leaves one ready cycle
    push(4'b1001, SET_C, SET_C, 5);   // R5 entry
    push(4'b0001, SRMIN, SRMIN, 6);   // R6 early wake acted on at min time
    push(4'b1001, HOLD, HOLD, 8);     // R8 column hold
    push(4'b1101, TAIL_F, TAIL_F, 8); // R8 fast precharge tail
    push(4'b1110, 12, 12, 9);         // R9 sleep in SR and wake in idle ignored
    push(4'b1001, SET_C, SET_C, 5);
    push(4'b0001, SRMIN, SRMIN, 5);
    push(4'b0000, 7, 7, 7);           // R7 parked window
    push(4'b1001, HOLD, HOLD, 8);
    push(4'b1101, TAIL_F, TAIL_F, 8);
    push(4'b1110, 2, 2, 4);           // R4 pulse on first ready cycle
    push(4'b1001, SET_C, SET_C, 6);   // R6 wake during entry latched
    push(4'b0001, SRMIN, SRMIN, 6);
    push(4'b1001, HOLD, HOLD, 8);
    push(4'b1101, TAIL_F, TAIL_F, 8);

    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;   // R4 before ready

    while (!ready) @(negedge clk);
    while (ras_n)  @(negedge clk);
    repeat (50) @(negedge clk);
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;   // R9 ignored in SR
    repeat (5) @(negedge clk);
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;     // R6 early wake

    while (!ready) @(negedge clk);
    repeat (2) @(negedge clk);
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;     // R9 ignored in idle
    repeat (7) @(negedge clk);
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;

    while (!(busy == 1'b0 && ras_n == 1'b0)) @(negedge clk);
    repeat (5) @(negedge clk);
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;     // R7 late wake

    while (!ready) @(negedge clk);
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
    while (cas_n) @(negedge clk);
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;     // R6 wake during entry

    while (!ready) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(ready == 1'b1, "R9", "ready stays high with no new request", ready, 1);
    chk(busy  == 1'b0, "R3", "busy low while ready", busy, 0);
    chk(ras_n == 1'b1, "R3", "ras_n high while ready", ras_n, 1);
    chk(cas_n == 1'b1, "R3", "cas_n high while ready", cas_n, 1);
    chk(exp_q.size() == 0, "R2", "segments left unseen", exp_q.size(), 0);
    finish_run();
  end
endmodule